// File: doc/BRIEF.md
# Registered Two-Port Bus Transceiver

This block links two 8-bit ports, A and B, and can move a word from either one to the other. Each direction of travel has its own storage register. The register for the A-to-B path is loaded from the A-port input on the rising edge of its own capture clock. The register for the B-to-A path is loaded from the B-port input on the rising edge of a second, independent capture clock. Loading never depends on the output controls, so a register can take a word even while both ports are isolated.

Each direction also has its own source select. That select decides whether the receiving port carries the live word from the opposite port's input, or the word held in that direction's register. One active-low enable and one direction line decide which port, if any, drives. The other port only listens.

Each port is modelled as separate input, output and per-bit output-enable vectors, with no real tri-state pins. An output vector always carries its multiplexed word. Only the output-enable vector tells the pad whether to drive.

Top module: `bus_xcvr_reg`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers to zero. After reset, a port whose select is 1 (stored) outputs 8'h00.
- R2: On every rising edge of `cap_ab_clk`, the A-to-B register loads `a_in`.
- R3: On every rising edge of `cap_ba_clk`, the B-to-A register loads `b_in`.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are both all zeros (isolation).
- R5: While `oe_n` is 0 and `dir` is 1, `b_oe` is all ones and `a_oe` is all zeros (A drives B).
- R6: While `oe_n` is 0 and `dir` is 0, `a_oe` is all ones and `b_oe` is all zeros (B drives A).
- R7: `b_out` equals the live `a_in` when `sel_ab` is 0, and the A-to-B register when `sel_ab` is 1.
- R8: `a_out` equals the live `b_in` when `sel_ba` is 0, and the B-to-A register when `sel_ba` is 1.
- R9: Both registers keep loading on their clock edges while the ports are isolated (`oe_n` = 1).
- R10: In a cycle where a capture edge and a live transfer happen together, the receiving port shows the live word both before and after the edge, and the register holds that same word afterwards.
- R11: A stored word stays unchanged when its port input changes without a capture edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_ab_clk | input | 1 | Capture clock for the A-to-B register |
| cap_ba_clk | input | 1 | Capture clock for the B-to-A register |
| sel_ab | input | 1 | Source for the B port: 0 live, 1 stored |
| sel_ba | input | 1 | Source for the A port: 0 live, 1 stored |
| oe_n | input | 1 | Output enable, active low; 1 isolates both ports |
| dir | input | 1 | 1: A drives B, 0: B drives A |
| a_in | input | 8 | Word arriving at the A port |
| a_out | output | 8 | Word presented for the A port |
| a_oe | output | 8 | Per-bit drive enable for the A port |
| b_in | input | 8 | Word arriving at the B port |
| b_out | output | 8 | Word presented for the B port |
| b_oe | output | 8 | Per-bit drive enable for the B port |

## Verification
The two functions that can fall in the same cycle are a register capture and a live pass-through along the same path. The bench provokes this by holding `sel_ab` at live with A driving B, then raising `cap_ab_clk` while `a_in` is steady. It judges the result by checking that `b_out` shows the live word before and after the edge. It then switches `sel_ab` to stored after `a_in` has changed and checks that the register kept the word present at the edge. One table row also raises both capture clocks at once while one path is live and the other is stored.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_W = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  import xcvr_pkg::*;
  src_sel_e src;

  always_comb begin
    src = src_sel_e'(sel);
    unique case (src)
      SRC_STORED: y = stored;
      default:    y = live;
    endcase
  end
endmodule

// File: rtl/xcvr_drive_dec.sv
module xcvr_drive_dec #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input  logic         oe_n,
  input  logic         dir,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_oe
);
  logic to_b, to_a;

  always_comb begin
    to_b = !oe_n &&  dir;
    to_a = !oe_n && !dir;
    b_oe = {W{to_b}};
    a_oe = {W{to_a}};
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH = xcvr_pkg::XCVR_W
) (
  input  logic             rst_n,
  input  logic             cap_ab_clk,
  input  logic             cap_ba_clk,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             oe_n,
  input  logic             dir,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);
  logic [WIDTH-1:0] ab_q;
  logic [WIDTH-1:0] ba_q;

  // A-to-B path: stores A-port word, feeds B port
  xcvr_cap_reg #(.W(WIDTH)) u_ab_reg (
    .clk(cap_ab_clk), .rst_n(rst_n), .d(a_in), .q(ab_q)
  );
  xcvr_src_mux #(.W(WIDTH)) u_ab_mux (
    .sel(sel_ab), .live(a_in), .stored(ab_q), .y(b_out)
  );

  // B-to-A path: stores B-port word, feeds A port
  xcvr_cap_reg #(.W(WIDTH)) u_ba_reg (
    .clk(cap_ba_clk), .rst_n(rst_n), .d(b_in), .q(ba_q)
  );
  xcvr_src_mux #(.W(WIDTH)) u_ba_mux (
    .sel(sel_ba), .live(b_in), .stored(ba_q), .y(a_out)
  );

  xcvr_drive_dec #(.W(WIDTH)) u_drive (
    .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
  );
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int WIDTH = xcvr_pkg::XCVR_W
) (
  input logic             rst_n,
  input logic             cap_ab_clk,
  input logic             cap_ba_clk,
  input logic             oe_n,
  input logic             dir,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_oe,
  input logic [WIDTH-1:0] b_oe,
  input logic [WIDTH-1:0] ab_q,
  input logic [WIDTH-1:0] ba_q
);
  AST_AB_LOAD: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    1'b1 |=> (ab_q == $past(a_in))); // R2
  AST_BA_LOAD: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    1'b1 |=> (ba_q == $past(b_in))); // R3
  AST_ISOLATE: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0)); // R4
  AST_A_TO_B: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    (!oe_n && dir) |-> (&b_oe && a_oe == '0)); // R5
  AST_B_TO_A: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    (!oe_n && !dir) |-> (&a_oe && b_oe == '0)); // R6
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_n(rst_n), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
  .oe_n(oe_n), .dir(dir), .a_in(a_in), .b_in(b_in),
  .a_oe(a_oe), .b_oe(b_oe), .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/tb_bus_xcvr_reg.sv
`timescale 1ns/1ps
module tb_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic         rst_n, cap_ab_clk, cap_ba_clk, sel_ab, sel_ba, oe_n, dir;
  logic [W-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;

  int compared = 0;
  int mismatched = 0;

  bus_xcvr_reg #(.WIDTH(W)) dut (
    .rst_n(rst_n), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_n(oe_n), .dir(dir),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // row: {oe_n,dir,sel_ab,sel_ba,pulse_ab,pulse_ba, a_in, b_in, exp_a_out, exp_b_out, exp_aoe, exp_boe}
  localparam int NROW = 8;
  localparam logic [39:0] VEC [NROW] = '{
    {6'b100000, 8'h11, 8'h22, 8'h22, 8'h11, 2'b00}, // R4 R7 R8 live, isolated
    {6'b011100, 8'h33, 8'h44, 8'h00, 8'h00, 2'b01}, // R1 R5 reset contents
    {6'b101110, 8'h5A, 8'h44, 8'h00, 8'h5A, 2'b00}, // R2 R9
    {6'b111101, 8'h66, 8'hC3, 8'hC3, 8'h5A, 2'b00}, // R3 R9
    {6'b001100, 8'hFF, 8'h00, 8'hC3, 8'h5A, 2'b10}, // R6 R11
    {6'b000000, 8'h12, 8'h34, 8'h34, 8'h12, 2'b10}, // R7 R8
    {6'b010111, 8'hA5, 8'h0F, 8'h0F, 8'hA5, 2'b01}, // R10 both edges
    {6'b011100, 8'h00, 8'h00, 8'h0F, 8'hA5, 2'b01}  // R11
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cap_ab_clk = 1'b0; cap_ba_clk = 1'b0;
    sel_ab = 1'b1; sel_ba = 1'b1; oe_n = 1'b1; dir = 1'b0;
    a_in = 8'h77; b_in = 8'h88;
    repeat (2) @(negedge clk);
    check("R1 reset b_out", b_out, 8'h00);
    check("R1 reset a_out", a_out, 8'h00);
    check("R4 reset a_oe", a_oe, 8'h00);
    check("R4 reset b_oe", b_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      {oe_n, dir, sel_ab, sel_ba} = VEC[i][39:36];
      a_in = VEC[i][33:26];
      b_in = VEC[i][25:18];
      @(posedge clk);
      cap_ab_clk = VEC[i][35];
      cap_ba_clk = VEC[i][34];
      @(negedge clk);
      check($sformatf("row%0d a_out", i), a_out, VEC[i][17:10]);
      check($sformatf("row%0d b_out", i), b_out, VEC[i][9:2]);
      check($sformatf("row%0d a_oe", i), a_oe, {W{VEC[i][1]}});
      check($sformatf("row%0d b_oe", i), b_oe, {W{VEC[i][0]}});
      cap_ab_clk = 1'b0; cap_ba_clk = 1'b0;
      @(negedge clk);
    end

    // R10: capture edge during live A-to-B transfer
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h3C;
    @(negedge clk);
    check("R10 live before edge", b_out, 8'h3C);
    @(posedge clk); cap_ab_clk = 1'b1;
    @(negedge clk);
    check("R10 live after edge", b_out, 8'h3C);
    cap_ab_clk = 1'b0; a_in = 8'hC0; sel_ab = 1'b1;
    @(negedge clk);
    check("R10 stored equals captured", b_out, 8'h3C);

    // R11: input changes with no edge leave the stored word alone
    a_in = 8'h99; b_in = 8'h66;
    @(negedge clk);
    check("R11 a-path hold", b_out, 8'h3C);
    sel_ba = 1'b1;
    @(negedge clk);
    check("R11 b-path hold", a_out, 8'h0F);

    // R9: load during isolation, then reveal
    oe_n = 1'b1; b_in = 8'hE1;
    @(posedge clk); cap_ba_clk = 1'b1;
    @(negedge clk);
    check("R4 isolated a_oe", a_oe, 8'h00);
    cap_ba_clk = 1'b0; oe_n = 1'b0; dir = 1'b0;
    @(negedge clk);
    check("R9 isolated load", a_out, 8'hE1);
    check("R6 a_oe drives", a_oe, 8'hFF);

    // R1: reset mid-run clears both registers
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 midrun b_out", b_out, 8'h00);
    check("R1 midrun a_out", a_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule